// File: doc/BRIEF.md
# Buffered Parallel-In Serial-Out Shifter

This block holds a word of parallel data in a staging register and moves it into a separate shift register. From there the word leaves one bit at a time on a serial output. The staging register captures its parallel inputs on the rising edge of a capture strobe. The shift register has three operations: an active-low clear, an active-low load that copies the staging register, and a rising edge on a separate shift strobe. On a shift edge, the first stage takes a serial input bit and every other stage takes the value of the stage before it. The serial output is the last stage.

The block runs in one fabric clock domain. Both strobes, both control lines and all data pins pass through a common chain of synchronizer flops, so they stay aligned with one another. Edges are then detected in the fabric clock. Clear and load act as level controls that need no strobe edge. Clear outranks load. While load is held, the shift register tracks the staging register, and this includes a capture made during the hold. A capture and a shift may occur on the same strobe edge. In that case the shift uses the old contents and the staging register takes the new word.

Top module: `buf_piso_shifter`

## Requirements
- R1: A rising edge on `cap_strobe` copies `par_in` into the staging register. Without such an edge the staging register keeps its value.
- R2: Clear, load and shift operations never change the staging register contents.
- R3: While `clr_n` is 0, every stage reads 0, whatever the state of `shift_strobe`, `load_n` and `ser_in`.
- R4: While `load_n` is 0 and `clr_n` is 1, stage i takes `par_in` bit i from the staging register, and no shift edge is needed. Bit WIDTH-1 therefore appears first on `ser_out`.
- R5: On a rising edge of `shift_strobe` with `clr_n` and `load_n` both 1, stage 0 takes `ser_in` and stage i takes stage i-1. A loaded word leaves MSB first, followed by the serial fill bits.
- R6: With `clr_n` and `load_n` both 1 and no shift edge, the shift register holds its state.
- R7: `ser_out` is the value of the last stage (index WIDTH-1).
- R8: When `clr_n` and `load_n` are both 0, the shift register reads all zeros.
- R9: While load is held, a new capture passes straight through to the shift register.
- R10: When both strobes rise together, the shift uses the old contents and the staging register takes the new word.
- R11: Synchronous active-high `srst` zeroes the staging register, the shift register and `ser_out`.
- R12: A change on any pin shows up on `ser_out` exactly SYNC_STAGES+1 `clk` cycles after the first `clk` edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| srst | input | 1 | Synchronous reset, active high |
| cap_strobe | input | 1 | Capture strobe for the staging register, rising edge |
| shift_strobe | input | 1 | Shift strobe, rising edge |
| clr_n | input | 1 | Clear shift register, active low, highest priority |
| load_n | input | 1 | Copy staging register into shift register, active low |
| ser_in | input | 1 | Serial fill bit for stage 0 |
| par_in | input | WIDTH | Parallel word; bit i maps to stage i |
| ser_out | output | 1 | Last stage of the shift register |

## Verification
Every result is due SYNC_STAGES+1 fabric cycles after the first edge that samples the stimulus. With the default of two synchronizer stages, that is three cycles. The bench changes pins on the falling edge of `clk`. It checks at least that many falling edges later, after the clear or load has settled or after the strobe has risen and fallen again. One scenario checks `ser_out` one cycle before the due edge and again on it. This shows the old value still held and then the new one present. Contents that cannot be seen directly are read out by shifting the whole word through `ser_out` and comparing each bit against a bench model of both registers.

// File: rtl/buf_piso_pkg.sv
package buf_piso_pkg;

  typedef enum logic [1:0] {
    SA_HOLD  = 2'd0,
    SA_CLEAR = 2'd1,
    SA_LOAD  = 2'd2,
    SA_SHIFT = 2'd3
  } shift_act_e;

  // Clear outranks load, load outranks shift.
  function automatic shift_act_e pick_act(input logic clr_n, input logic load_n,
                                          input logic shift_rise);
    if (!clr_n)         return SA_CLEAR;
    else if (!load_n)   return SA_LOAD;
    else if (shift_rise) return SA_SHIFT;
    else                return SA_HOLD;
  endfunction

endpackage

// File: rtl/pin_sampler.sv
module pin_sampler #(
  parameter int unsigned          BW      = 8,
  parameter int unsigned          DEPTH   = 2,
  parameter logic [BW-1:0]        RST_VAL = '0
) (
  input  logic          clk,
  input  logic          srst,
  input  logic [BW-1:0] raw,
  output logic [BW-1:0] smp
);
  logic [BW-1:0] chain [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (srst) chain[g] <= RST_VAL;
        else      chain[g] <= raw;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (srst) chain[g] <= RST_VAL;
        else      chain[g] <= chain[g-1];
      end
    end
  end

  assign smp = chain[DEPTH-1];
endmodule

// File: rtl/rise_detect.sv
module rise_detect #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         srst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (srst) prev_q <= '0;
    else      prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/stage_reg.sv
module stage_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             cap,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (srst)     q <= '0;
    else if (cap) q <= d;
  end
endmodule

// File: rtl/piso_cell.sv
module piso_cell
  import buf_piso_pkg::*;
(
  input  logic       clk,
  input  logic       srst,
  input  shift_act_e act,
  input  logic       load_bit,
  input  logic       left_bit,
  output logic       q
);
  always_ff @(posedge clk) begin
    if (srst) q <= 1'b0;
    else begin
      unique case (act)
        SA_CLEAR: q <= 1'b0;
        SA_LOAD:  q <= load_bit;
        SA_SHIFT: q <= left_bit;
        default:  q <= q;
      endcase
    end
  end
endmodule

// File: rtl/buf_piso_shifter.sv
module buf_piso_shifter
  import buf_piso_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             cap_strobe,
  input  logic             shift_strobe,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out
);
  localparam int unsigned BW = WIDTH + 5;
  localparam logic [BW-1:0] IDLE_PINS = {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, {WIDTH{1'b0}}};

  logic [BW-1:0]    raw_pins, smp_pins;
  logic             s_cap, s_shift, s_clr_n, s_ld_n, s_ser;
  logic [WIDTH-1:0] s_par;
  logic [1:0]       rises;
  logic             st_rise, sh_rise;
  logic [WIDTH-1:0] store_q, load_val, sh_q;
  shift_act_e       act;

  assign raw_pins = {cap_strobe, shift_strobe, clr_n, load_n, ser_in, par_in};

  pin_sampler #(.BW(BW), .DEPTH(SYNC_STAGES), .RST_VAL(IDLE_PINS)) u_sampler (
    .clk(clk), .srst(srst), .raw(raw_pins), .smp(smp_pins)
  );

  assign {s_cap, s_shift, s_clr_n, s_ld_n, s_ser, s_par} = smp_pins;

  rise_detect #(.N(2)) u_rise (
    .clk(clk), .srst(srst), .lvl({s_cap, s_shift}), .rise(rises)
  );
  assign st_rise = rises[1];
  assign sh_rise = rises[0];

  stage_reg #(.WIDTH(WIDTH)) u_store (
    .clk(clk), .srst(srst), .cap(st_rise), .d(s_par), .q(store_q)
  );

  // A capture during a held load passes straight through.
  assign load_val = st_rise ? s_par : store_q;
  assign act      = pick_act(s_clr_n, s_ld_n, sh_rise);

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic left_bit;
    if (i == 0) begin : g_first
      assign left_bit = s_ser;
    end else begin : g_rest
      assign left_bit = sh_q[i-1];
    end
    piso_cell u_cell (
      .clk(clk), .srst(srst), .act(act), .load_bit(load_val[i]),
      .left_bit(left_bit), .q(sh_q[i])
    );
  end

  assign ser_out = sh_q[WIDTH-1];
endmodule

// File: rtl/buf_piso_shifter_chk.sv
module buf_piso_shifter_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             srst,
  input logic             st_rise,
  input logic             sh_rise,
  input logic             s_clr_n,
  input logic             s_ld_n,
  input logic             s_ser,
  input logic [WIDTH-1:0] s_par,
  input logic [WIDTH-1:0] store_q,
  input logic [WIDTH-1:0] sh_q
);
  AST_CAPTURE_WORD: assert property (@(posedge clk) disable iff (srst)
    st_rise |=> store_q == $past(s_par)); // R1
  AST_STORE_KEPT: assert property (@(posedge clk) disable iff (srst)
    !st_rise |=> $stable(store_q)); // R2
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (srst)
    !s_clr_n |=> sh_q == '0); // R3
  AST_CLEAR_BEATS_LOAD: assert property (@(posedge clk) disable iff (srst)
    (!s_clr_n && !s_ld_n) |=> sh_q == '0); // R8
  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (srst)
    (s_clr_n && !s_ld_n) |=> sh_q == store_q); // R4
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (srst)
    (s_clr_n && s_ld_n && sh_rise) |=>
      sh_q == {$past(sh_q[WIDTH-2:0]), $past(s_ser)}); // R5
  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (srst)
    (s_clr_n && s_ld_n && !sh_rise) |=> $stable(sh_q)); // R6
endmodule

bind buf_piso_shifter buf_piso_shifter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .srst(srst), .st_rise(st_rise), .sh_rise(sh_rise),
  .s_clr_n(s_clr_n), .s_ld_n(s_ld_n), .s_ser(s_ser), .s_par(s_par),
  .store_q(store_q), .sh_q(sh_q)
);

// File: tb/buf_piso_shifter_bench.sv
`timescale 1ns/1ps
module buf_piso_shifter_bench;
  localparam int W   = 8;
  localparam int SS  = 2;
  localparam int LAT = SS + 1;

  logic clk = 1'b0;
  logic srst, cap_strobe, shift_strobe, clr_n, load_n, ser_in, ser_out;
  logic [W-1:0] par_in;
  logic [W-1:0] m_store, m_sh;
  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  buf_piso_shifter #(.WIDTH(W), .SYNC_STAGES(SS)) u_buf_piso_shifter (
    .clk(clk), .srst(srst), .cap_strobe(cap_strobe), .shift_strobe(shift_strobe),
    .clr_n(clr_n), .load_n(load_n), .ser_in(ser_in), .par_in(par_in), .ser_out(ser_out)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s ser_out actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_st(input logic [W-1:0] d);
    par_in = d; cap_strobe = 1'b1; step(1);
    cap_strobe = 1'b0; step(LAT);
    m_store = d;
    if (clr_n && !load_n) m_sh = d;
  endtask

  task automatic pulse_sh(input logic b);
    ser_in = b; shift_strobe = 1'b1; step(1);
    shift_strobe = 1'b0; step(LAT);
    if (clr_n && load_n) m_sh = {m_sh[W-2:0], b};
  endtask

  task automatic set_ctl(input logic c, input logic l);
    clr_n = c; load_n = l; step(LAT);
    if (!c) m_sh = '0;
    else if (!l) m_sh = m_store;
  endtask

  // Shift n bits out, checking each against the model; fill with a pattern.
  task automatic read_out(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      chk(req, ser_out, m_sh[W-1]);
      pulse_sh(i[0] ^ i[2]);
    end
  endtask

  task automatic t_reset;
    par_in = 8'hFF; ser_in = 1'b1; step(4);
    srst = 1'b0; step(2);
    chk("R11 reset", ser_out, 1'b0);
    set_ctl(1'b1, 1'b0); set_ctl(1'b1, 1'b1);
    read_out("R11 staging zero", W);
  endtask

  task automatic t_capture_load;
    pulse_st(8'hB4);
    chk("R1 no load yet", ser_out, m_sh[W-1]);
    set_ctl(1'b1, 1'b0);
    chk("R4 load no strobe", ser_out, 1'b1);
    set_ctl(1'b1, 1'b1);
    read_out("R4 R7 load map", W);
  endtask

  task automatic t_shift_fill;
    pulse_st(8'h5A); set_ctl(1'b1, 1'b0); set_ctl(1'b1, 1'b1);
    read_out("R5 shift and fill", 2 * W);
  endtask

  task automatic t_hold;
    pulse_st(8'hC6); set_ctl(1'b1, 1'b0); set_ctl(1'b1, 1'b1);
    par_in = 8'h39; ser_in = 1'b0; step(6);
    ser_in = 1'b1; step(6);
    chk("R6 hold", ser_out, 1'b1);
    read_out("R6 hold contents", W);
  endtask

  task automatic t_clear;
    pulse_st(8'hFF); set_ctl(1'b1, 1'b0); set_ctl(1'b1, 1'b1);
    chk("R3 pre-clear", ser_out, 1'b1);
    set_ctl(1'b0, 1'b1);
    chk("R3 clear", ser_out, 1'b0);
    pulse_sh(1'b1); pulse_sh(1'b1);
    chk("R3 clear blocks shift", ser_out, 1'b0);
    set_ctl(1'b1, 1'b1);
    read_out("R3 all zero", W);
  endtask

  task automatic t_clr_ld;
    pulse_st(8'hFF);
    set_ctl(1'b0, 1'b0);
    chk("R8 clear wins", ser_out, 1'b0);
    set_ctl(1'b1, 1'b0);
    chk("R8 load after clear", ser_out, 1'b1);
    set_ctl(1'b1, 1'b1);
    read_out("R8 contents", W);
  endtask

  task automatic t_isolation;
    pulse_st(8'hA5);
    set_ctl(1'b0, 1'b1); pulse_sh(1'b1); set_ctl(1'b1, 1'b1);
    pulse_sh(1'b1); pulse_sh(1'b0);
    set_ctl(1'b0, 1'b0); set_ctl(1'b1, 1'b1);
    set_ctl(1'b1, 1'b0); set_ctl(1'b1, 1'b1);
    read_out("R2 staging untouched", W);
  endtask

  task automatic t_follow;
    pulse_st(8'h00);
    set_ctl(1'b1, 1'b0);
    chk("R9 before", ser_out, 1'b0);
    pulse_st(8'h93);
    chk("R9 follow", ser_out, 1'b1);
    set_ctl(1'b1, 1'b1);
    read_out("R9 contents", W);
  endtask

  task automatic t_tied;
    pulse_st(8'h3C); set_ctl(1'b1, 1'b0); set_ctl(1'b1, 1'b1);
    par_in = 8'hC3; ser_in = 1'b1;
    cap_strobe = 1'b1; shift_strobe = 1'b1; step(1);
    cap_strobe = 1'b0; shift_strobe = 1'b0; step(LAT);
    m_sh = {m_sh[W-2:0], 1'b1}; m_store = 8'hC3;
    read_out("R10 old shifted", W);
    set_ctl(1'b1, 1'b0); set_ctl(1'b1, 1'b1);
    read_out("R10 new captured", W);
  endtask

  task automatic t_latency;
    set_ctl(1'b0, 1'b1); set_ctl(1'b1, 1'b1);
    pulse_st(8'h80);
    load_n = 1'b0; step(LAT - 1);
    chk("R12 not yet", ser_out, 1'b0);
    step(1);
    chk("R12 due", ser_out, 1'b1);
    m_sh = m_store;
    load_n = 1'b1; step(LAT);
    read_out("R12 contents", W);
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    srst = 1'b1; cap_strobe = 1'b0; shift_strobe = 1'b0;
    clr_n = 1'b1; load_n = 1'b1; ser_in = 1'b0; par_in = '0;
    m_store = '0; m_sh = '0;
    t_reset();
    t_capture_load();
    t_shift_fill();
    t_hold();
    t_clear();
    t_clr_ld();
    t_isolation();
    t_follow();
    t_tied();
    t_latency();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule